// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block connects a byte-organised processor to a bit-serial time-division highway. A frame holds 32 time slots of 8 bits each. A frame-sync input marks where each frame begins. Received serial bits are packed into bytes and stored by slot index. Bytes that the processor has written are shifted out on the transmit line, one per slot. The serial data clock, frame sync and receive data are oversampled by the fabric clock. The serial side therefore runs entirely on edge strobes in one clock domain.

Both directions use two banks of storage that exchange roles once per frame. The processor works on a whole frame that the serial side no longer touches. Each read returns a 16-bit word. The low byte holds the stored slot byte and the high byte comes from a programmable prefix register. The word can then index a companding expansion table directly. The data clock can run at one or two cycles per bit.

Top module: `pcm_tdm_port`

## Requirements
- R1: A frame is 32 slots of 8 bits. When the frame-sync input is sampled high, the bit sampled at that same point is bit 7 of slot 0, and later bits follow in slot order.
- R2: Received bits are packed most significant bit first. Slot s of a received frame is readable at processor address s once the next frame has started.
- R3: A processor read of address s (cpu_addr[5]=0) returns {prefix, byte} one clock after the address is presented. A write with cpu_addr[5]=1 loads the low 8 bits of cpu_wdata into the prefix. A new prefix appears on later reads and the slot byte is unchanged.
- R4: Transmit bits leave most significant bit first. txd changes only after a rising data-clock edge and holds a bit's value at that bit's sampling edge.
- R5: Bytes written with cpu_addr[5]=0 during one frame are transmitted in the next frame, in slot order. The transmit bank exchanges when slot 0 is loaded.
- R6: With dbl_rate=1 each bit lasts two data-clock cycles. Receive data and frame sync are taken only at the falling edge of the second cycle, and the transmit bit holds for both cycles.
- R7: While frame N arrives, reads return frame N-1 unchanged.
- R8: A frame sync arriving before 32 slots have completed realigns to slot 0, bit 7 and sets framing_err. framing_err stays set until reset. Full-length frames never set it.
- R9: During reset txd is 0, framing_err is 0 and cpu_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; must be at least 6 times the data-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| dbl_rate | input | 1 | 0: one data-clock cycle per bit; 1: two cycles per bit |
| dclk | input | 1 | Serial data clock |
| fsync | input | 1 | Frame-sync input, high during the first bit |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| cpu_addr | input | 6 | Bits 4:0 slot index; bit 5 selects the prefix register |
| cpu_we | input | 1 | Processor write strobe |
| cpu_wdata | input | 8 | Transmit byte or prefix value |
| cpu_rdata | output | 16 | {prefix, received slot byte} |
| framing_err | output | 1 | Sticky short-frame flag |

## Verification
Several distinct receive and transmit patterns run frame after frame in single-rate mode. A slot or bit-order error therefore shows as a wrong byte at a known address, or as a wrong bit at a known edge. Reads placed early and late in a frame separate correct bank exchange from a buffer that the live frame overwrites. A prefix change in mid-frame shows that the high byte follows the register while the low byte does not change. A 10-slot frame followed by full frames covers the resync, the sticky flag and the recovery of alignment. The double-rate run uses a sync pulse only in the second clock of the bit, which shows that sampling happens on the second cycle only.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_DOUBLE = 1'b1
  } rate_e;
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic dclk_i,
  input  logic fsync_i,
  input  logic rxd_i,
  output logic rise_o,
  output logic fall_o,
  output logic fsync_o,
  output logic rxd_o
);
  logic [STAGES:0]   dclk_sh;
  logic [STAGES-1:0] fsync_sh;
  logic [STAGES-1:0] rxd_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk_sh  <= '0;
      fsync_sh <= '0;
      rxd_sh   <= '0;
    end else begin
      dclk_sh  <= {dclk_sh[STAGES-1:0], dclk_i};
      fsync_sh <= {fsync_sh[STAGES-2:0], fsync_i};
      rxd_sh   <= {rxd_sh[STAGES-2:0], rxd_i};
    end
  end

  // data and sync travel through the same depth as the clock
  assign rise_o  = dclk_sh[STAGES-1] & ~dclk_sh[STAGES];
  assign fall_o  = ~dclk_sh[STAGES-1] & dclk_sh[STAGES];
  assign fsync_o = fsync_sh[STAGES-1];
  assign rxd_o   = rxd_sh[STAGES-1];
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_tdm_pkg::*;
#(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  rate_e         mode_i,
  input  logic          fall_i,
  input  logic          fsync_i,
  output logic          samp_o,
  output logic          sof_o,
  output logic [SW-1:0] pos_slot_o,
  output logic [BW-1:0] pos_bit_o,
  output logic [SW-1:0] slot_q_o,
  output logic [BW-1:0] bit_q_o,
  output logic          err_o
);
  localparam logic [BW-1:0] TOP_BIT   = BW'(BITS - 1);
  localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

  logic          ph_q;
  logic          locked_q;
  logic          err_q;
  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;
  logic          samp;
  logic          sof;
  logic [SW-1:0] pos_slot;
  logic [BW-1:0] pos_bit;

  // unlocked double-rate: any falling edge with sync high becomes the sampling edge
  always_comb begin
    samp     = fall_i && (mode_i == RATE_SINGLE || ph_q || (!locked_q && fsync_i));
    sof      = samp && fsync_i;
    pos_slot = sof ? '0 : slot_q;
    pos_bit  = sof ? TOP_BIT : bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= 1'b0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
      slot_q   <= '0;
      bit_q    <= TOP_BIT;
    end else begin
      if (fall_i) ph_q <= !samp;
      if (samp) begin
        if (sof) locked_q <= 1'b1;
        if (sof && locked_q && (slot_q != '0 || bit_q != TOP_BIT)) err_q <= 1'b1;
        if (pos_bit == '0) begin
          bit_q  <= TOP_BIT;
          slot_q <= (pos_slot == LAST_SLOT) ? '0 : pos_slot + 1'b1;
        end else begin
          bit_q  <= pos_bit - 1'b1;
          slot_q <= pos_slot;
        end
      end
    end
  end

  assign samp_o     = samp;
  assign sof_o      = sof;
  assign pos_slot_o = pos_slot;
  assign pos_bit_o  = pos_bit;
  assign slot_q_o   = slot_q;
  assign bit_q_o    = bit_q;
  assign err_o      = err_q;

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  a_r1_resync_pos: assert property (@(posedge clk) disable iff (rst)
    sof |=> (slot_q == '0 && bit_q == TOP_BIT - 1'b1));
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            samp_i,
  input  logic            sof_i,
  input  logic            rxd_i,
  input  logic [SW-1:0]   pos_slot_i,
  input  logic [BW-1:0]   pos_bit_i,
  input  logic [SW-1:0]   rd_slot_i,
  input  logic [BITS-1:0] prefix_i,
  output logic [2*BITS-1:0] rdata_o
);
  logic [BITS-2:0] sh_q;
  logic [BITS-1:0] byte_w;
  logic            wbank_q;
  logic [BITS-1:0] mem [2*SLOTS];
  logic [BITS-1:0] rd_q;
  logic [BITS-1:0] pfx_q;

  assign byte_w = {sh_q, rxd_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q    <= '0;
      wbank_q <= 1'b0;
    end else begin
      if (samp_i) sh_q <= byte_w[BITS-2:0];
      if (sof_i) wbank_q <= ~wbank_q;
    end
  end

  // serial write port into the live bank
  always_ff @(posedge clk) begin
    if (samp_i && pos_bit_i == '0) mem[{wbank_q, pos_slot_i}] <= byte_w;
  end

  // processor read port on the settled bank
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      pfx_q <= '0;
    end else begin
      rd_q  <= mem[{~wbank_q, rd_slot_i}];
      pfx_q <= prefix_i;
    end
  end

  assign rdata_o = {pfx_q, rd_q};

  a_r3_prefix_high: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rdata_o[2*BITS-1:BITS] == $past(prefix_i));
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path #(
  parameter int SLOTS = 32,
  parameter int BITS  = 8,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rise_i,
  input  logic            samp_i,
  input  logic [SW-1:0]   slot_q_i,
  input  logic [BW-1:0]   bit_q_i,
  input  logic            we_i,
  input  logic [SW-1:0]   wr_slot_i,
  input  logic [BITS-1:0] wdata_i,
  output logic            txd_o
);
  localparam logic [BW-1:0] TOP_BIT = BW'(BITS - 1);

  logic            pend_q;
  logic            sbank_q;
  logic [BITS-1:0] mem [2*SLOTS];
  logic [BITS-1:0] rd_q;
  logic [BITS-1:0] sr_q;
  logic [SW:0]     rd_addr;
  logic            shift_now;

  // prefetch the byte of the coming slot; slot 0 comes from the bank about to take over
  assign rd_addr   = {(slot_q_i == '0) ? ~sbank_q : sbank_q, slot_q_i};
  assign shift_now = rise_i && pend_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[{~sbank_q, wr_slot_i}] <= wdata_i;
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      sbank_q <= 1'b0;
      sr_q    <= '0;
    end else begin
      if (samp_i) pend_q <= 1'b1;
      else if (rise_i) pend_q <= 1'b0;
      if (shift_now) begin
        if (bit_q_i == TOP_BIT) begin
          sr_q <= rd_q;
          if (slot_q_i == '0) sbank_q <= ~sbank_q;
        end else begin
          sr_q <= {sr_q[BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign txd_o = sr_q[BITS-1];

  a_r4_txd_on_rise: assert property (@(posedge clk) disable iff (rst)
    !rise_i |=> $stable(txd_o));
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
  import pcm_tdm_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int BITS   = 8,
  parameter int STAGES = 2,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbl_rate,
  input  logic              dclk,
  input  logic              fsync,
  input  logic              rxd,
  output logic              txd,
  input  logic [SW:0]       cpu_addr,
  input  logic              cpu_we,
  input  logic [BITS-1:0]   cpu_wdata,
  output logic [2*BITS-1:0] cpu_rdata,
  output logic              framing_err
);
  logic            rise, fall, fsync_s, rxd_s;
  logic            samp, sof;
  logic [SW-1:0]   pos_slot, slot_q;
  logic [BW-1:0]   pos_bit, bit_q;
  logic [BITS-1:0] prefix_q;
  logic            tx_we;
  rate_e           mode;

  assign mode  = rate_e'(dbl_rate);
  assign tx_we = cpu_we && !cpu_addr[SW];

  always_ff @(posedge clk) begin
    if (rst) prefix_q <= '0;
    else if (cpu_we && cpu_addr[SW]) prefix_q <= cpu_wdata;
  end

  pcm_in_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .dclk_i(dclk), .fsync_i(fsync), .rxd_i(rxd),
    .rise_o(rise), .fall_o(fall), .fsync_o(fsync_s), .rxd_o(rxd_s)
  );

  pcm_frame_timer #(.SLOTS(SLOTS), .BITS(BITS)) u_timer (
    .clk(clk), .rst(rst), .mode_i(mode), .fall_i(fall), .fsync_i(fsync_s),
    .samp_o(samp), .sof_o(sof), .pos_slot_o(pos_slot), .pos_bit_o(pos_bit),
    .slot_q_o(slot_q), .bit_q_o(bit_q), .err_o(framing_err)
  );

  pcm_rx_path #(.SLOTS(SLOTS), .BITS(BITS)) u_rx (
    .clk(clk), .rst(rst), .samp_i(samp), .sof_i(sof), .rxd_i(rxd_s),
    .pos_slot_i(pos_slot), .pos_bit_i(pos_bit), .rd_slot_i(cpu_addr[SW-1:0]),
    .prefix_i(prefix_q), .rdata_o(cpu_rdata)
  );

  pcm_tx_path #(.SLOTS(SLOTS), .BITS(BITS)) u_tx (
    .clk(clk), .rst(rst), .rise_i(rise), .samp_i(samp), .slot_q_i(slot_q),
    .bit_q_i(bit_q), .we_i(tx_we), .wr_slot_i(cpu_addr[SW-1:0]),
    .wdata_i(cpu_wdata), .txd_o(txd)
  );
endmodule

// File: tb/pcm_tdm_port_bench.sv
module pcm_tdm_port_bench;
  localparam int SLOTS = 32;
  localparam int HALF  = 6;
  localparam logic [5:0] PFX_ADDR = 6'h20;
  typedef logic [7:0] frame_t [SLOTS];

  logic clk = 0, rst = 1, dbl = 0, dclk = 0, fsync = 0, rxd = 0;
  logic txd, cpu_we = 0, framing_err;
  logic [5:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;

  int nchk = 0, nerr = 0;
  bit tx_q[$];
  logic [15:0] rd_q[$];
  string rd_tag_q[$];
  string tx_tag = "R4";
  logic rd_stb = 0, rd_pend = 0;
  event tx_ev;

  always #10 clk = ~clk;

  pcm_tdm_port u_pcm_tdm_port (
    .clk(clk), .rst(rst), .dbl_rate(dbl), .dclk(dclk), .fsync(fsync), .rxd(rxd),
    .txd(txd), .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .framing_err(framing_err)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic frame_t mk(int seed);
    frame_t f;
    for (int s = 0; s < SLOTS; s++) f[s] = 8'((s * 29) + (seed * 53) + 7);
    return f;
  endfunction

  // monitors
  always @(tx_ev) begin
    if (tx_q.size() > 0) begin
      bit e;
      e = tx_q.pop_front();
      check(txd === e, tx_tag, int'(txd), int'(e));
    end
  end

  always @(posedge clk) rd_pend <= rd_stb;
  always @(negedge clk) begin
    if (rd_pend && rd_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = rd_q.pop_front();
      t = rd_tag_q.pop_front();
      check(cpu_rdata === e, t, int'(cpu_rdata), int'(e));
    end
  end

  // drivers
  task automatic send_bit(bit v, bit fs, bit chk);
    int cyc;
    cyc = dbl ? 2 : 1;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      dclk = 1; rxd = v; fsync = fs && (c == cyc - 1);
      repeat (HALF) @(negedge clk);
      if (chk && c == cyc - 1) -> tx_ev;
      dclk = 0;
      repeat (HALF - 1) @(negedge clk);
    end
  endtask

  task automatic run_frame(frame_t rxb, int nsl, bit chk, frame_t txb);
    if (chk)
      for (int s = 0; s < nsl; s++)
        for (int b = 7; b >= 0; b--) tx_q.push_back(txb[s][b]);
    for (int s = 0; s < nsl; s++)
      for (int b = 7; b >= 0; b--) send_bit(rxb[s][b], s == 0 && b == 7, chk);
  endtask

  task automatic cpu_write(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic cpu_read(int s, logic [15:0] e, string tag);
    @(negedge clk);
    cpu_addr = 6'(s); rd_stb = 1;
    rd_q.push_back(e); rd_tag_q.push_back(tag);
    @(negedge clk);
    rd_stb = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    frame_t p0, p1, p2, p3, p4, p5, p6, p7, p8, t1, t2, t3, t4;
    p0 = mk(1); p1 = mk(2); p2 = mk(3); p3 = mk(4); p4 = mk(5);
    p5 = mk(6); p6 = mk(7); p7 = mk(8); p8 = mk(9);
    t1 = mk(11); t2 = mk(12); t3 = mk(13); t4 = mk(14);

    repeat (5) @(negedge clk);
    check(txd === 1'b0, "R9", int'(txd), 0);
    check(framing_err === 1'b0, "R9", int'(framing_err), 0);
    check(cpu_rdata === 16'h0, "R9", int'(cpu_rdata), 0);
    rst = 0;
    repeat (3) @(negedge clk);

    // single rate
    cpu_write(PFX_ADDR, 8'hA5);
    for (int s = 0; s < SLOTS; s++) cpu_write(6'(s), t1[s]);
    run_frame(p0, SLOTS, 0, t1);
    tx_tag = "R4";
    fork
      run_frame(p1, SLOTS, 1, t1);
      begin
        repeat (300) @(negedge clk);
        cpu_read(0, {8'hA5, p0[0]}, "R1");
        for (int s = 0; s < SLOTS; s++) cpu_read(s, {8'hA5, p0[s]}, "R2");
        for (int s = 0; s < SLOTS; s++) cpu_write(6'(s), t2[s]);
        cpu_write(PFX_ADDR, 8'h5A);
        cpu_read(3, {8'h5A, p0[3]}, "R3");
        cpu_read(31, {8'h5A, p0[31]}, "R1");
        repeat (2000) @(negedge clk);
        cpu_read(0, {8'h5A, p0[0]}, "R7");
        cpu_read(20, {8'h5A, p0[20]}, "R7");
      end
    join
    tx_tag = "R5";
    fork
      run_frame(p2, SLOTS, 1, t2);
      begin
        repeat (300) @(negedge clk);
        for (int s = 0; s < SLOTS; s++) cpu_read(s, {8'h5A, p1[s]}, "R7");
      end
    join
    check(framing_err === 1'b0, "R8", int'(framing_err), 0);

    // short frame of 10 slots
    run_frame(p3, 10, 0, t2);
    fork
      run_frame(p4, SLOTS, 0, t2);
      begin
        repeat (300) @(negedge clk);
        check(framing_err === 1'b1, "R8", int'(framing_err), 1);
        for (int s = 0; s < 10; s++) cpu_read(s, {8'h5A, p3[s]}, "R8");
      end
    join
    fork
      run_frame(p5, SLOTS, 0, t2);
      begin
        repeat (300) @(negedge clk);
        for (int s = 0; s < SLOTS; s++) cpu_read(s, {8'h5A, p4[s]}, "R8");
        check(framing_err === 1'b1, "R8", int'(framing_err), 1);
      end
    join

    // double rate
    rst = 1; dbl = 1;
    repeat (5) @(negedge clk);
    check(framing_err === 1'b0, "R9", int'(framing_err), 0);
    rst = 0;
    repeat (3) @(negedge clk);
    cpu_write(PFX_ADDR, 8'h3C);
    for (int s = 0; s < SLOTS; s++) cpu_write(6'(s), t3[s]);
    run_frame(p6, SLOTS, 0, t3);
    tx_tag = "R6";
    fork
      run_frame(p7, SLOTS, 1, t3);
      begin
        repeat (300) @(negedge clk);
        for (int s = 0; s < SLOTS; s++) cpu_read(s, {8'h3C, p6[s]}, "R6");
        for (int s = 0; s < SLOTS; s++) cpu_write(6'(s), t4[s]);
      end
    join
    fork
      run_frame(p8, SLOTS, 1, t4);
      begin
        repeat (300) @(negedge clk);
        for (int s = 0; s < SLOTS; s++) cpu_read(s, {8'h3C, p7[s]}, "R6");
      end
    join
    check(framing_err === 1'b0, "R6", int'(framing_err), 0);
    check(tx_q.size() == 0, "R4", tx_q.size(), 0);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule